// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Controller

This block bridges a simple synchronous request port to an external asynchronous static RAM of 65,536 sixteen-bit words. A requester presents one access at a time (a read or a write) with a word address, write data and a per-byte lane mask. The controller then sequences the memory's active-low select, write strobe, output strobe and the two lane strobes. It finishes every access with a one-cycle completion pulse, which carries the read word on a read.

The shared data bus is split into an outgoing word, an incoming word and a drive-enable. This lets the pad ring or a behavioural model resolve the bus. The controller drives the bus only inside the write strobe. It keeps the bus released for a full cycle before it opens the memory's output. Wait-cycle counts for the read access and the write strobe are parameters. They are chosen so that the read window covers the memory's 8 ns address-to-data time at the clock in use.

The state machine has seven states. IDLE accepts a request. A write then runs WR_SETUP, WR_PULSE and WR_HOLD. A read runs RD_TURN and RD_WAIT. Both paths end in DONE, which always returns to IDLE. The transitions are:
- IDLE to WR_SETUP or to RD_TURN on an accepted request.
- WR_SETUP to WR_PULSE after one cycle.
- WR_PULSE to WR_HOLD when the write count expires.
- WR_HOLD to DONE after one cycle.
- RD_TURN to RD_WAIT after one cycle.
- RD_WAIT to DONE when the read count expires.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and right after it, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n and mem_lb_n are high, mem_dq_oe is low, req_ready is high and rsp_valid is low.
- R2: req_ready is high only in IDLE. A request is taken at a rising edge where req_valid and req_ready are both high, and req_ready stays low until the access finishes.
- R3: A write drives the address, mem_ce_n low and the lane strobes for one cycle before mem_we_n falls. It then keeps mem_we_n low for exactly WR_WAIT cycles. The address, chip select and lane strobes are held for one cycle after mem_we_n rises.
- R4: A write changes only the byte lanes whose req_be bit is 1. Other lanes of the addressed word keep their previous contents.
- R5: A read spends one cycle with mem_ce_n low and mem_oe_n high. It then holds mem_oe_n low for exactly RD_WAIT cycles, with mem_we_n high throughout.
- R6: Read data is sampled in the last cycle of the output window. Lanes whose req_be bit is 0 come back as zero.
- R7: mem_dq_oe is high only while mem_we_n and mem_ce_n are both low, and never while mem_oe_n is low. The controller and the memory never drive the bus in the same cycle.
- R8: rsp_valid is a single-cycle pulse. It appears RD_WAIT+1 rising edges after a read is accepted and WR_WAIT+2 rising edges after a write is accepted. rsp_rdata is zero on a write completion.
- R9: req_be bit 0 maps to the lower lane (data bits 7..0, mem_lb_n). Bit 1 maps to the upper lane (data bits 15..8, mem_ub_n). A strobe is driven low only when its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Lane mask, bit 1 upper, bit 0 lower |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 16 | Read word, masked lanes zero |
| mem_addr | output | 16 | Memory address lines |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_dq_out | output | 16 | Word driven onto the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 16 | Word sampled from the data bus |

## Verification
Two functions can meet on the data bus in the same cycle: the controller's write drive and the memory's read drive. The most likely point is when a read directly follows a write. The bench provokes this by issuing reads and writes back to back, each new request raised as soon as req_ready returns. A behavioural memory model drives the bus whenever its select, output and lane strobes permit. Every cycle, the bench records any cycle in which that model and mem_dq_oe are both active, and it fails the run if any such cycle occurs. The same overlap is guarded inside the controller by a checker on the strobes.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_TURN,
        ST_RD_WAIT,
        ST_DONE
    } ctrl_state_e;

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int RD_WAIT = 2,
    parameter int WR_WAIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_rd,
    output logic last
);
    localparam int MAXW  = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
    localparam int CNT_W = (MAXW > 1) ? $clog2(MAXW) : 1;
    localparam logic [CNT_W-1:0] RD_END = CNT_W'(RD_WAIT - 1);
    localparam logic [CNT_W-1:0] WR_END = CNT_W'(WR_WAIT - 1);

    logic [CNT_W-1:0] cnt;

    assign last = run && (cnt == (sel_rd ? RD_END : WR_END));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dout[g*LANE_W +: LANE_W] <= '0;
            end else if (clear) begin
                dout[g*LANE_W +: LANE_W] <= '0;
            end else if (load) begin
                dout[g*LANE_W +: LANE_W] <= be[g] ? din[g*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int RD_WAIT = 2,
    parameter int WR_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int LANES = 2;

    ctrl_state_e state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              accept;
    logic              tmr_run;
    logic              tmr_last;
    logic              lanes_on;

    assign accept = req_valid && (state == ST_IDLE);

    sram_wait_timer #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .sel_rd (state == ST_RD_WAIT),
        .last   (tmr_last)
    );

    sram_lane_capture #(.DATA_W(DATA_W), .LANES(LANES)) capture_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .load  ((state == ST_RD_WAIT) && tmr_last),
        .be    (be_q),
        .din   (mem_dq_in),
        .dout  (rsp_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_nx = req_write ? ST_WR_SETUP : ST_RD_TURN;
            ST_WR_SETUP: state_nx = ST_WR_PULSE;
            ST_WR_PULSE: if (tmr_last) state_nx = ST_WR_HOLD;
            ST_WR_HOLD:  state_nx = ST_DONE;
            ST_RD_TURN:  state_nx = ST_RD_WAIT;
            ST_RD_WAIT:  if (tmr_last) state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        lanes_on  = 1'b0;
        tmr_run   = 1'b0;
        unique case (state)
            ST_IDLE:     req_ready = 1'b1;
            ST_WR_SETUP: begin mem_ce_n = 1'b0; lanes_on = 1'b1; end
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
                lanes_on  = 1'b1;
                tmr_run   = 1'b1;
            end
            ST_WR_HOLD:  begin mem_ce_n = 1'b0; lanes_on = 1'b1; end
            ST_RD_TURN:  begin mem_ce_n = 1'b0; lanes_on = 1'b1; end
            ST_RD_WAIT:  begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
                lanes_on = 1'b1;
                tmr_run  = 1'b1;
            end
            ST_DONE:     rsp_valid = 1'b1;
            default:     ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_lb_n   = !(lanes_on && be_q[0]);
    assign mem_ub_n   = !(lanes_on && be_q[1]);
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic              mem_dq_oe
);
    AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n));                              // R7
    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n));                              // R7
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> ($past(!mem_dq_oe) && $past(!mem_ce_n)));         // R5
    AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr)
                             && $stable(mem_ub_n) && $stable(mem_lb_n)));    // R3
    AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && $stable(mem_addr)
                             && $stable(mem_ub_n) && $stable(mem_lb_n)));    // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                            // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);                                            // R2
    AST_STROBES_NEED_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_ub_n && mem_lb_n && mem_we_n && mem_oe_n));        // R1
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;
    localparam int RD_WAIT = 2;
    localparam int WR_WAIT = 2;

    typedef struct {
        bit          is_read;
        logic [15:0] data;
        int          t_acc;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [15:0] req_addr = 0, req_wdata = 0;
    logic [1:0]  req_be = 0;
    logic req_ready, rsp_valid;
    logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
    logic mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;

    int checks = 0, fails = 0, cyc = 0, clash = 0;
    int we_low = 0, oe_low = 0, done_cnt = 0;
    bit finished = 0;
    exp_t q[$];
    logic [15:0] model[logic [15:0]];
    logic [15:0] shadow[logic [15:0]];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_lane_ctrl #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) dut_i (.*);

    // Behavioural memory: drives enabled lanes when read strobes allow
    logic        mdrv;
    logic [15:0] mword;
    always_comb begin
        mdrv  = !mem_ce_n && !mem_oe_n && mem_we_n && !(mem_ub_n && mem_lb_n);
        mword = model.exists(mem_addr) ? model[mem_addr] : 16'h0000;
        if (mem_ub_n) mword[15:8] = 8'h00;
        if (mem_lb_n) mword[7:0]  = 8'h00;
        mem_dq_in = mdrv ? mword : (mem_dq_oe ? mem_dq_out : 16'h0000);
    end
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            logic [15:0] w;
            w = model.exists(mem_addr) ? model[mem_addr] : 16'h0000;
            if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
            model[mem_addr] = w;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: issues one request and pushes its expected result
    task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
        exp_t e;
        logic [15:0] s;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 0;
        s = shadow.exists(a) ? shadow[a] : 16'h0000;
        e.is_read = !wr;
        e.t_acc   = cyc;
        if (wr) begin
            if (be[0]) s[7:0]  = d[7:0];
            if (be[1]) s[15:8] = d[15:8];
            shadow[a] = s;
            e.data = 16'h0000;
        end else begin
            e.data = {be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00};
        end
        q.push_back(e);
        check(!req_ready, "R2 ready low while busy", {31'd0, req_ready}, 32'd0);
    endtask

    // Monitor: strobe counting, bus clash watch and scoreboard compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (mdrv && mem_dq_oe) clash++;
            if (!mem_we_n) we_low++;
            if (!mem_oe_n) oe_low++;
            if (!mem_ub_n && !req_be_seen[1]) ube_bad++;
            if (!mem_lb_n && !req_be_seen[0]) lbe_bad++;
            if (rsp_valid) begin
                exp_t e;
                done_cnt++;
                if (q.size() == 0) begin
                    check(0, "R8 unexpected done", 32'd1, 32'd0);
                end else begin
                    e = q.pop_front();
                    check(rsp_rdata == e.data, e.is_read ? "R6 read data" : "R8 write done data",
                          {16'd0, rsp_rdata}, {16'd0, e.data});
                    check(cyc - e.t_acc == (e.is_read ? RD_WAIT + 1 : WR_WAIT + 2), "R8 latency",
                          cyc - e.t_acc, e.is_read ? RD_WAIT + 1 : WR_WAIT + 2);
                    if (e.is_read)
                        check(oe_low == RD_WAIT && we_low == 0, "R5 output window",
                              oe_low, RD_WAIT);
                    else
                        check(we_low == WR_WAIT && oe_low == 0, "R3 write strobe width",
                              we_low, WR_WAIT);
                end
                we_low = 0;
                oe_low = 0;
            end
        end
    end

    // Lane strobes must match the mask of the access in flight (R9)
    logic [1:0] req_be_seen = 2'b00;
    int ube_bad = 0, lbe_bad = 0;
    always @(posedge clk) if (req_valid && req_ready) req_be_seen <= req_be;

    initial begin
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe,
              "R1 reset strobes", {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}, 32'h1f);
        check(req_ready && !rsp_valid, "R1 reset handshake", {30'd0, req_ready, rsp_valid}, 32'd2);
        rst_n = 1;
        @(negedge clk);
        check(mem_ce_n && req_ready, "R1 after reset", {30'd0, mem_ce_n, req_ready}, 32'd3);

        issue(1, 16'h0000, 16'h1234, 2'b11);   // R4 full write
        issue(0, 16'h0000, 16'h0000, 2'b11);   // R6 full read
        issue(1, 16'h0000, 16'hABCD, 2'b01);   // R9 lower lane only
        issue(0, 16'h0000, 16'h0000, 2'b11);   // R4 upper kept -> 12CD
        issue(1, 16'h0000, 16'h5E77, 2'b10);   // R9 upper lane only
        issue(0, 16'h0000, 16'h0000, 2'b01);   // R6 lower lane read, upper zero
        issue(0, 16'h0000, 16'h0000, 2'b10);   // R6 upper lane read, lower zero
        issue(1, 16'hFFFF, 16'hC3A5, 2'b11);   // top address
        issue(1, 16'hFFFF, 16'h0000, 2'b00);   // R4 empty mask changes nothing
        issue(0, 16'hFFFF, 16'h0000, 2'b11);
        issue(0, 16'hFFFF, 16'h0000, 2'b00);   // R6 no lanes -> zero
        for (int i = 0; i < 8; i++) begin
            issue(1, 16'(i * 16'h1111), 16'(16'h0F0F ^ (i * 16'h0707)), 2'(i % 4));
            issue(0, 16'(i * 16'h1111), 16'h0000, 2'b11);
        end
        repeat (8) @(negedge clk);
        check(q.size() == 0, "R8 all completions seen", q.size(), 0);
        check(clash == 0, "R7 bus clash cycles", clash, 0);
        check(ube_bad == 0 && lbe_bad == 0, "R9 lane strobe vs mask", ube_bad + lbe_bad, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc == 20000);
        if (!finished) begin
            check(0, "watchdog expired", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule